// File: doc/BRIEF.md
# Nibble-Serial Program Memory Interface

This block connects a processor that speaks over a 4-bit multiplexed bus to a byte-wide program store. Each instruction cycle has eight bus phases. In the first three phases the processor sends a 12-bit program address, one nibble per phase, starting with the least significant nibble. The block asks a synchronous program store for the byte at that address. It latches the byte and returns it to the processor over the same four wires: the upper nibble in the first memory phase and the lower nibble in the second. In every other phase the block leaves the bus undriven.

The wires on the processor side use the opposite sense to the internal logic: an internal one travels as a low level on the pin. The block inverts every nibble it receives and every nibble it sends. The block also recognises I/O-read instructions by their upper nibble. For such an instruction it raises a strobe during one execute phase and shows the port number on four select outputs.

Top module: `nib_prog_if`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block returns to the first address phase. After that edge `io_rd` is 0, `port_sel` is 0 and `bus_oe` is 0, and the latched instruction is cleared.
- R2: Without a sync request, the phase moves forward by one on every clock, in the order A1, A2, A3, M1, M2, X1, X2, X3. After X3 it wraps to A1.
- R3: If `sync_n` is low at a rising edge, the next phase is A1 whatever the current phase is.
- R4: Bus data uses the opposite sense to internal data. The internal nibble equals the bitwise inverse of `bus_in`, and `bus_out` carries the bitwise inverse of the internal nibble. When the bus is not driven, `bus_out` reads 4'hF.
- R5: The A1 nibble is program address bits [3:0] and the A2 nibble is bits [7:4]. During A3 `rom_en` is 1 and `rom_addr` shows the full 12-bit address, with bits [11:8] taken from the bus in that same phase. `rom_en` is 0 in every other phase.
- R6: The program store returns its byte on `rom_data` one clock after `rom_en`. During M1, `bus_oe` is 1 and `bus_out` carries the upper instruction nibble, bits [7:4].
- R7: During M2, `bus_oe` is 1 and `bus_out` carries the lower nibble, bits [3:0], of the instruction latched at the end of M1. `bus_oe` is 0 in A1, A2, A3, X1, X2 and X3.
- R8: An instruction whose bits [7:4] equal 4'hE is an I/O read. For such an instruction `io_rd` is 1 during exactly the X2 phase of its cycle and is 0 again in X3. For any other instruction `io_rd` stays 0.
- R9: On entry to X2 of an I/O-read cycle, `port_sel` takes bits [3:0] of that instruction. It keeps that value until the next I/O read or a reset.
- R10: If a sync request ends a cycle before X2, no strobe is issued for that cycle and `port_sel` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bus phase per cycle |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Cycle-start request, active low; next phase is A1 |
| bus_in | input | 4 | Bus level seen at the pins (inverted sense) |
| bus_out | output | 4 | Bus level driven by the block (inverted sense) |
| bus_oe | output | 1 | High while the block drives the bus |
| rom_en | output | 1 | Read request to the program store |
| rom_addr | output | 12 | Program address for the read request |
| rom_data | input | 8 | Byte from the program store, one clock after the request |
| io_rd | output | 1 | I/O-read strobe, high only in X2 |
| port_sel | output | 4 | Number of the selected I/O port |

## Verification
Each result falls due in one of four phase slots:
- The read request and its address appear in the same phase as the third address nibble.
- The upper instruction nibble appears one clock later, in M1.
- The lower instruction nibble appears in M2.
- The strobe and the port number appear together two clocks after M2, in X2.

The bench follows the phase order itself. It changes inputs on the falling edge and checks each phase's outputs a moment later, so every comparison falls inside the phase where its result is due. It checks that the other outputs stay quiet in that phase as well. It sweeps all 4096 addresses, alternates between explicit sync and natural wrap, and cuts cycles short with sync at M1, A2 and X1.

// File: rtl/nib_prog_pkg.sv
package nib_prog_pkg;

    localparam int NIB_W     = 4;
    localparam int ADDR_NIBS = 3;
    localparam int ADDR_W    = NIB_W * ADDR_NIBS;
    localparam int INSTR_W   = 2 * NIB_W;

    typedef enum logic [2:0] {
        PH_A1 = 3'd0,
        PH_A2 = 3'd1,
        PH_A3 = 3'd2,
        PH_M1 = 3'd3,
        PH_M2 = 3'd4,
        PH_X1 = 3'd5,
        PH_X2 = 3'd6,
        PH_X3 = 3'd7
    } phase_t;

    typedef logic [NIB_W-1:0]   nib_t;
    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [ADDR_W-1:0]  paddr_t;

    // Pin level to internal value: the bus carries inverted sense.
    function automatic nib_t pin2nib(input nib_t p);
        return ~p;
    endfunction

    function automatic nib_t nib2pin(input nib_t n);
        return ~n;
    endfunction

    function automatic phase_t phase_after(input phase_t p, input logic sync);
        phase_t r;
        if (sync || p == PH_X3) r = PH_A1;
        else                    r = phase_t'(p + 3'd1);
        return r;
    endfunction

    function automatic nib_t hi_nib(input instr_t i);
        return i[INSTR_W-1:NIB_W];
    endfunction

    function automatic nib_t lo_nib(input instr_t i);
        return i[NIB_W-1:0];
    endfunction

endpackage

// File: rtl/nib_phase_seq.sv
module nib_phase_seq
    import nib_prog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sync,
    output phase_t ph_q,
    output phase_t ph_nxt
);

    always_comb ph_nxt = phase_after(ph_q, sync);

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_A1;
        else     ph_q <= ph_nxt;
    end

    // R2: free-running advance
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (!sync && ph_q != PH_X3) |=> ph_q == phase_t'($past(ph_q) + 3'd1));

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (!sync && ph_q == PH_X3) |=> ph_q == PH_A1);

    // R3: sync realigns from any phase
    a_r3_sync: assert property (@(posedge clk) disable iff (rst)
        sync |=> ph_q == PH_A1);

endmodule

// File: rtl/nib_addr_collect.sv
module nib_addr_collect
    import nib_prog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph_q,
    input  nib_t   bus_nib,
    output paddr_t rom_addr,
    output logic   rom_en
);

    localparam int STORED = ADDR_NIBS - 1;

    nib_t nib_q [STORED];

    for (genvar g = 0; g < STORED; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)                         nib_q[g] <= '0;
            else if (ph_q == phase_t'(g))    nib_q[g] <= bus_nib;
        end
    end

    // Last address nibble is used straight from the bus in its own phase.
    always_comb begin
        rom_addr = '0;
        for (int k = 0; k < STORED; k++)
            rom_addr[k*NIB_W +: NIB_W] = nib_q[k];
        rom_addr[STORED*NIB_W +: NIB_W] = bus_nib;
    end

    assign rom_en = (ph_q == phase_t'(STORED));

    // R5: low nibble held once A2 has been entered
    a_r5_lo_hold: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_A1) |=> rom_addr[NIB_W-1:0] == $past(bus_nib));

endmodule

// File: rtl/nib_instr_feed.sv
module nib_instr_feed
    import nib_prog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph_q,
    input  instr_t rom_data,
    output instr_t instr_q,
    output nib_t   drv_nib,
    output logic   drv_en
);

    always_ff @(posedge clk) begin
        if (rst)                 instr_q <= '0;
        else if (ph_q == PH_M1)  instr_q <= rom_data;
    end

    // M1 forwards the fresh store word; M2 reads the latch.
    always_comb begin
        drv_en  = 1'b0;
        drv_nib = '0;
        unique case (ph_q)
            PH_M1: begin drv_en = 1'b1; drv_nib = hi_nib(rom_data); end
            PH_M2: begin drv_en = 1'b1; drv_nib = lo_nib(instr_q);  end
            default: ;
        endcase
    end

    // R7: the nibble driven in M2 is the one captured at the M1 edge
    a_r7_latch: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_M1) |=> instr_q == $past(rom_data));

endmodule

// File: rtl/nib_port_decode.sv
module nib_port_decode
    import nib_prog_pkg::*;
#(
    parameter nib_t IO_RD_OPC = 4'hE
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph_nxt,
    input  instr_t instr_q,
    output logic   io_rd,
    output nib_t   port_sel
);

    logic past_ok_q;
    logic fire;

    assign fire = (ph_nxt == PH_X2) && (hi_nib(instr_q) == IO_RD_OPC);

    always_ff @(posedge clk) begin
        if (rst) begin
            io_rd     <= 1'b0;
            port_sel  <= '0;
            past_ok_q <= 1'b0;
        end else begin
            io_rd     <= fire;
            past_ok_q <= 1'b1;
            if (fire) port_sel <= lo_nib(instr_q);
        end
    end

    // R8: strobe is a single-phase pulse
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        io_rd |=> !io_rd);

    // R9: selection only moves together with the strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (past_ok_q && !io_rd) |-> $stable(port_sel));

endmodule

// File: rtl/nib_prog_if.sv
module nib_prog_if
    import nib_prog_pkg::*;
#(
    parameter logic [3:0] IO_RD_OPC = 4'hE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sync_n,
    input  logic [3:0]  bus_in,
    output logic [3:0]  bus_out,
    output logic        bus_oe,
    output logic        rom_en,
    output logic [11:0] rom_addr,
    input  logic [7:0]  rom_data,
    output logic        io_rd,
    output logic [3:0]  port_sel
);

    logic   sync;
    phase_t ph_q, ph_nxt;
    nib_t   bus_nib, drv_nib;
    instr_t instr_q;

    assign sync    = ~sync_n;
    assign bus_nib = pin2nib(bus_in);
    assign bus_out = nib2pin(drv_nib);

    nib_phase_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .sync   (sync),
        .ph_q   (ph_q),
        .ph_nxt (ph_nxt)
    );

    nib_addr_collect u_addr (
        .clk      (clk),
        .rst      (rst),
        .ph_q     (ph_q),
        .bus_nib  (bus_nib),
        .rom_addr (rom_addr),
        .rom_en   (rom_en)
    );

    nib_instr_feed u_feed (
        .clk      (clk),
        .rst      (rst),
        .ph_q     (ph_q),
        .rom_data (rom_data),
        .instr_q  (instr_q),
        .drv_nib  (drv_nib),
        .drv_en   (bus_oe)
    );

    nib_port_decode #(.IO_RD_OPC(IO_RD_OPC)) u_port (
        .clk      (clk),
        .rst      (rst),
        .ph_nxt   (ph_nxt),
        .instr_q  (instr_q),
        .io_rd    (io_rd),
        .port_sel (port_sel)
    );

    // R6: a read request without sync leads into the driven M1 phase
    a_r6_req_then_drive: assert property (@(posedge clk) disable iff (rst)
        (rom_en && !sync) |=> bus_oe);

    // R6: driving only starts right after a read request
    a_r6_rise_after_req: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(rom_en));

    // R8: strobe only ever seen in the X2 phase
    a_r8_only_x2: assert property (@(posedge clk) disable iff (rst)
        io_rd |-> ph_q == PH_X2);

    // R1: reset leaves the outputs quiet
    a_r1_quiet: assert property (@(posedge clk)
        rst |=> (!io_rd && port_sel == 4'h0 && !bus_oe));

    // R10: a sync request never yields a strobe in the next phase
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (rst)
        sync |=> !io_rd);

endmodule

// File: tb/test_nib_prog_if.sv
module test_nib_prog_if;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_n = 1'b1;
    logic [3:0]  bus_in = 4'hF;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic        rom_en;
    logic [11:0] rom_addr;
    logic [7:0]  rom_data = 8'h00;
    logic        io_rd;
    logic [3:0]  port_sel;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_port = 4'h0;

    always #2 clk = ~clk;   // 250 MHz

    nib_prog_if i_nib_prog_if (
        .clk(clk), .rst(rst), .sync_n(sync_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .rom_en(rom_en),
        .rom_addr(rom_addr), .rom_data(rom_data), .io_rd(io_rd),
        .port_sel(port_sel)
    );

    function automatic logic [7:0] rom_fn(input logic [11:0] a);
        logic [19:0] m;
        m = {8'd0, a} * 20'd173;
        return m[9:2] ^ a[11:4];
    endfunction

    // Program store model: registered read, one clock latency
    always_ff @(posedge clk) if (rom_en) rom_data <= rom_fn(rom_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Runs one instruction cycle starting at the current falling edge (A1).
    // cut: phase index at which sync is asserted to end the cycle early (-1: none).
    task automatic run_instr(input logic [11:0] a, input bit sync_end, input int cut);
        logic [7:0] d;
        bit io;
        d  = rom_fn(a);
        io = (d[7:4] == 4'hE);
        for (int p = 0; p < 8; p++) begin
            sync_n = 1'b1;
            case (p)
                0: bus_in = ~a[3:0];
                1: bus_in = ~a[7:4];
                2: bus_in = ~a[11:8];
                default: bus_in = 4'hF;
            endcase
            if (p == cut) sync_n = 1'b0;
            if (p == 7 && sync_end) sync_n = 1'b0;
            #1;
            // R5: address request only in A3
            if (p == 2) begin
                chk(rom_en == 1'b1, "R5 rom_en in A3", rom_en, 1);
                chk(rom_addr == a, "R5 rom_addr assembled", rom_addr, a);
            end else begin
                chk(rom_en == 1'b0, "R5 rom_en outside A3", rom_en, 0);
            end
            // R4 R6 R7: bus drive
            if (p == 3) begin
                chk(bus_oe == 1'b1, "R6 oe in M1", bus_oe, 1);
                chk(bus_out == ~d[7:4], "R6 R4 upper nibble", bus_out, ~d[7:4]);
            end else if (p == 4) begin
                chk(bus_oe == 1'b1, "R7 oe in M2", bus_oe, 1);
                chk(bus_out == ~d[3:0], "R7 R4 lower nibble", bus_out, ~d[3:0]);
            end else begin
                chk(bus_oe == 1'b0, "R7 bus released", bus_oe, 0);
                chk(bus_out == 4'hF, "R4 idle level", bus_out, 4'hF);
            end
            // R8 R9: strobe and port number
            if (p == 6) begin
                if (io) exp_port = d[3:0];
                chk(io_rd == io, "R8 strobe in X2", io_rd, io);
            end else begin
                chk(io_rd == 1'b0, "R8 no strobe outside X2", io_rd, 0);
            end
            chk(port_sel == exp_port, "R9 port_sel", port_sel, exp_port);
            @(negedge clk);
            if (p == cut) break;
        end
        sync_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] io_a;
        logic [11:0] plain_a;
        io_a = 12'h000;
        plain_a = 12'h000;
        for (int k = 0; k < 4096; k++) begin
            logic [7:0] dd;
            dd = rom_fn(12'(k));
            if (dd[7:4] == 4'hE && dd[3:0] != 4'h0) io_a = 12'(k);
            if (dd[7:4] != 4'hE) plain_a = 12'(k);
        end

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(io_rd == 1'b0, "R1 io_rd reset", io_rd, 0);
        chk(port_sel == 4'h0, "R1 port_sel reset", port_sel, 0);
        chk(bus_oe == 1'b0, "R1 bus_oe reset", bus_oe, 0);
        rst = 1'b0;

        // R2: natural wrap without sync, then R3 explicit sync
        run_instr(plain_a, 1'b0, -1);
        run_instr(io_a, 1'b1, -1);

        // Near-exhaustive sweep, alternating sync and free wrap (R2 R3)
        for (int a = 0; a < 4096; a++)
            run_instr(12'(a), a[0], -1);

        // R3: sync in M1 cuts the cycle; next cycle must start clean at A1
        run_instr(plain_a, 1'b0, 3);
        run_instr(io_a, 1'b1, -1);

        // R10: sync in X1 of an I/O read suppresses strobe and update
        run_instr(plain_a, 1'b1, -1);
        exp_port = port_sel;
        run_instr(io_a ^ 12'h000, 1'b0, 5);
        chk(io_rd == 1'b0, "R10 no strobe after cut", io_rd, 0);
        chk(port_sel == exp_port, "R10 port_sel kept", port_sel, exp_port);
        run_instr(plain_a, 1'b1, -1);

        // R3: sync during A2
        run_instr(io_a, 1'b0, 1);
        run_instr(io_a, 1'b1, -1);

        // R1: reset mid-cycle clears the port selection
        run_instr(12'h000, 1'b0, 4);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(port_sel == 4'h0, "R1 port_sel cleared", port_sel, 0);
        chk(io_rd == 1'b0, "R1 io_rd cleared", io_rd, 0);
        chk(bus_oe == 1'b0, "R1 bus_oe cleared", bus_oe, 0);
        exp_port = 4'h0;
        rst = 1'b0;
        run_instr(plain_a, 1'b1, -1);
        run_instr(io_a, 1'b1, -1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule